// File: doc/BRIEF.md
# UART Receive Buffer with Interrupt Generation

This block sits between a UART deserializer and the CPU on the receive side. The deserializer hands over each received byte with a single-cycle write strobe. The CPU removes bytes with a read strobe. A mode input selects one of two storage schemes: a one-byte holding register, or a 16-entry first-in first-out queue. The block raises a level interrupt that tells the CPU when to come and collect data.

In holding mode the interrupt follows the presence of an unread byte. In queue mode the interrupt is raised in two cases. The first is when the queue reaches half its depth. The second is when data has sat unread while the line stayed quiet for three character times, which the block measures by counting an external per-character tick. Once raised in queue mode, the interrupt stays up until the CPU has emptied the queue.

A byte that arrives when no room is left is discarded and sets a sticky overrun flag, which only a dedicated clear strobe removes. Any change of the mode input discards all stored data.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: In queue mode (fifo_en=1) up to 16 bytes are stored and `full` is 1 exactly when 16 are held. In holding mode (fifo_en=0) one byte is stored and `full` is 1 while it is held. `empty` is 1 when nothing is stored.
- R2: In holding mode `irq` is 1 while the stored byte is unread, and the read of that byte drops it to 0.
- R3: In queue mode `irq` becomes 1 on the clock edge that brings the stored count to 8 or more.
- R4: In queue mode `irq` becomes 1 on the clock edge that takes the idle count to 3, provided the queue is not empty. The idle count is the number of `char_tick` pulses since the last accepted write or read.
- R5: In queue mode, once `irq` is 1 it stays 1 until a read leaves the queue empty.
- R6: An accepted write or read resets the idle count to zero. The count stops at 3.
- R7: A write strobe while `full` is 1 leaves the stored data unchanged and sets `overrun`. `overrun` stays 1 until an `ovr_clr` pulse.
- R8: A read strobe while `empty` is 1 leaves `rd_data`, `empty` and the stored data unchanged.
- R9: In the cycle after `fifo_en` changes value, all stored data is discarded, the idle count is cleared and `irq` is 0. Strobes in the cycle of the change are ignored.
- R10: A write and a read in the same cycle, with data stored and `full` at 0, leave the count unchanged. `irq` is evaluated on that unchanged count.
- R11: After a synchronous reset the block is empty, with `full`, `irq` and `overrun` at 0, and it is in holding mode.
- R12: Bytes are read out in arrival order. The popped byte appears on `rd_data` right after the clock edge that samples the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects holding mode |
| wr_en | input | 1 | Write strobe from the deserializer |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Read strobe from the CPU |
| rd_data | output | 8 | Last byte popped |
| char_tick | input | 1 | One pulse per character time |
| ovr_clr | input | 1 | Clears the overrun flag |
| empty | output | 1 | Nothing stored |
| full | output | 1 | No room for another byte |
| overrun | output | 1 | Sticky flag for a dropped byte |
| irq | output | 1 | Level interrupt request |

## Verification
The deserializer's write and the CPU's read can land on the same clock edge. The bench provokes this by raising both strobes together with seven bytes stored, one below the interrupt threshold. A correct design keeps the count at seven, holds the interrupt low and returns the oldest byte. A following single write must then raise the interrupt, which proves the count really stayed at seven. The bench also pairs a write against a full store with a read-free cycle and a read against an empty store with a write-free cycle, to confirm that each strobe is refused alone.

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq #(
  parameter int DW         = 8,
  parameter int DEPTH      = 16,
  parameter int IDLE_CHARS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          char_tick,
  input  logic          ovr_clr,
  output logic          empty,
  output logic          full,
  output logic          overrun,
  output logic          irq
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DEPTH / 2;
  localparam int IW   = $clog2(IDLE_CHARS + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_n, cap;
  logic [IW-1:0] idle, idle_n;
  logic          mode_q, flush, do_wr, do_rd, irq_n;

  assign flush = fifo_en != mode_q;
  assign cap   = mode_q ? CW'(DEPTH) : CW'(1);
  assign empty = cnt == '0;
  assign full  = cnt == cap;
  assign do_wr = wr_en && !full && !flush;
  assign do_rd = rd_en && !empty && !flush;
  assign cnt_n = flush ? '0 : cnt + CW'(do_wr) - CW'(do_rd);

  always_comb begin
    if (flush || do_wr || do_rd)
      idle_n = '0;
    else if (char_tick && idle != IW'(IDLE_CHARS))
      idle_n = idle + IW'(1);
    else
      idle_n = idle;
  end

  always_comb begin
    if (flush || cnt_n == '0)
      irq_n = 1'b0;
    else if (!mode_q)
      irq_n = 1'b1;
    else
      irq_n = irq || cnt_n >= CW'(HALF) || idle_n == IW'(IDLE_CHARS);
  end

  always_ff @(posedge clk)
    if (do_wr) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      idle    <= '0;
      mode_q  <= 1'b0;
      irq     <= 1'b0;
      overrun <= 1'b0;
      rd_data <= '0;
    end else begin
      mode_q <= fifo_en;
      cnt    <= cnt_n;
      idle   <= idle_n;
      irq    <= irq_n;
      if (flush) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (do_wr) wp <= wp + AW'(1);
        if (do_rd) begin
          rp      <= rp + AW'(1);
          rd_data <= mem[rp];
        end
      end
      if (wr_en && full && !flush) overrun <= 1'b1;
      else if (ovr_clr)            overrun <= 1'b0;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R1
  AST_HOLD_IRQ: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (irq == !empty)); // R2
  AST_HALF_IRQ: assert property (@(posedge clk) disable iff (rst)
    (mode_q && cnt >= CW'(HALF)) |-> irq); // R3
  AST_DRAIN_ONLY: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> empty); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && !flush) |=> (overrun && $stable(cnt))); // R7
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en && !flush) |=> ($stable(rd_data) && empty)); // R8
endmodule

// File: tb/sim_uart_rx_fifo_irq.sv
module sim_uart_rx_fifo_irq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, char_tick = 1'b0, ovr_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       empty, full, overrun, irq;
  int         vecs = 0, errs = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  uart_rx_fifo_irq u0 (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .char_tick(char_tick), .ovr_clr(ovr_clr),
    .empty(empty), .full(full), .overrun(overrun), .irq(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(logic [7:0] b);
    wr_en = 1'b1; wr_data = b; cyc(); wr_en = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1; cyc(); rd_en = 1'b0;
  endtask

  task automatic tick();
    char_tick = 1'b1; cyc(); char_tick = 1'b0;
  endtask

  task automatic set_mode(logic m);
    fifo_en = m; cyc();
  endtask

  task automatic t_reset();
    rst = 1'b1; cyc(); cyc(); rst = 1'b0;
    chk("R11", "empty", empty, 1); chk("R11", "full", full, 0);
    chk("R11", "irq", irq, 0);     chk("R11", "overrun", overrun, 0);
  endtask

  task automatic t_hold();
    push(8'hA5);
    chk("R2", "irq after byte", irq, 1); chk("R1", "hold full", full, 1);
    push(8'h3C);
    chk("R7", "overrun", overrun, 1);
    pop();
    chk("R2", "data", rd_data, 8'hA5); chk("R2", "irq after read", irq, 0);
    chk("R1", "empty", empty, 1);
    cyc();
    chk("R7", "overrun sticky", overrun, 1);
    ovr_clr = 1'b1; cyc(); ovr_clr = 1'b0;
    chk("R7", "overrun cleared", overrun, 0);
  endtask

  task automatic t_half();
    set_mode(1'b1);
    for (int i = 0; i < 7; i++) push(8'h10 + 8'(i));
    chk("R3", "irq at 7", irq, 0);
    push(8'h17);
    chk("R3", "irq at 8", irq, 1);
    for (int i = 0; i < 8; i++) begin
      pop();
      chk("R12", "order", rd_data, 8'h10 + 8'(i));
      if (i < 7) chk("R5", "irq held", irq, 1);
    end
    chk("R5", "irq after drain", irq, 0); chk("R1", "empty", empty, 1);
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) push(8'(i * 3 + 1));
    chk("R1", "full at 16", full, 1);
    push(8'hEE);
    chk("R7", "overrun on full", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      pop();
      chk("R7", "kept data", rd_data, 8'(i * 3 + 1));
    end
    chk("R7", "extra dropped", empty, 1);
    ovr_clr = 1'b1; cyc(); ovr_clr = 1'b0;
  endtask

  task automatic t_empty_rd();
    pop();
    chk("R8", "rd_data kept", rd_data, 8'(15 * 3 + 1)); chk("R8", "still empty", empty, 1);
    push(8'h5A); pop();
    chk("R8", "pointers intact", rd_data, 8'h5A); chk("R8", "empty after", empty, 1);
  endtask

  task automatic t_timeout();
    push(8'h01); push(8'h02);
    tick(); tick();
    chk("R4", "irq after 2 ticks", irq, 0);
    push(8'h03);
    tick(); tick();
    chk("R6", "idle reset by write", irq, 0);
    tick();
    chk("R4", "irq after 3 ticks", irq, 1);
    tick();
    chk("R6", "saturated", irq, 1);
    pop(); tick(); tick();
    chk("R5", "held after read", irq, 1);
    pop(); pop();
    chk("R5", "drop at empty", irq, 0);
  endtask

  task automatic t_rdwr();
    for (int i = 0; i < 7; i++) push(8'h40 + 8'(i));
    wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h47; cyc(); wr_en = 1'b0; rd_en = 1'b0;
    chk("R10", "irq on unchanged 7", irq, 0); chk("R10", "oldest out", rd_data, 8'h40);
    push(8'h48);
    chk("R10", "count was 7", irq, 1);
    for (int i = 1; i < 9; i++) begin
      pop();
      chk("R12", "order after overlap", rd_data, 8'h40 + 8'(i));
    end
    chk("R10", "drained", empty, 1);
  endtask

  task automatic t_flush();
    push(8'h61); push(8'h62); push(8'h63);
    set_mode(1'b0);
    chk("R9", "empty after toggle", empty, 1); chk("R9", "irq after toggle", irq, 0);
    push(8'h64);
    chk("R9", "hold works", irq, 1); chk("R9", "hold full", full, 1);
    set_mode(1'b1);
    chk("R9", "empty after toggle back", empty, 1);
    push(8'h65); tick(); tick();
    set_mode(1'b0); set_mode(1'b1);
    push(8'h66); tick(); tick();
    chk("R9", "idle cleared", irq, 0);
    pop();
    chk("R9", "only new byte", rd_data, 8'h66);
    chk("R9", "empty", empty, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_hold();
    t_half();
    t_full();
    t_empty_rd();
    t_timeout();
    t_rdwr();
    t_flush();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      vecs++; errs++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule